// File: doc/BRIEF.md
# Parallel-Port SRAM Data Cartridge

This block is a model of a 4 KB battery-backed data cartridge as a host sees it on a small synchronous I/O bus. A host bus with a 2-bit register select reaches four registers. Three of them are output latches of a cut-down parallel peripheral port that supports only basic input/output mode. The fourth is a mode byte. The latches drive two 2 KB SRAM banks directly. There is no access sequencer between the latches and the memory.

The host builds a memory address from the low-address latch and from the low bits of the control latch. The control latch also holds a chip-enable bit and a read/write-direction bit. Data moves through the third latch. Its direction comes from the last mode byte written. Because the SRAM watches the latches all the time, the host must follow a strict order: set up data and address first, then raise enable, then drop it. Every latch update made while the chip is enabled for writing stores a byte, and this includes any address the host passes through along the way. If the SRAM outputs are switched on while the data port is driving, the block flags bus contention and leaves memory alone.

Top module: `ppi_sram_cart`

## Requirements
- R1: Register select 0 is the low-address latch, 1 is the control latch, 2 is the data port and 3 is the mode byte. A read of select 0 or 1 returns the value last written to it.
- R2: The memory address has 12 bits. Bits 7..0 come from latch 0. Bits 11..8 come from latch 1 bits 3..0. Address bit 11 (latch 1 bit 3) picks bank 0 or bank 1.
- R3: A mode write stores the byte and clears latches 0, 1 and 2 to 0, which drops the chip enable. Mode bit 0 = 1 (for example 0x89) makes the data port an input. Mode bit 0 = 0 (for example 0x80) makes it an output.
- R4: The store condition is: latch 1 bit 6 = 1 (enable), bit 7 = 0 (write), the data port is an output, and the bank exists. While it holds, every write to latch 0, 1 or 2 stores the data latch at the current address on the clock edge after the host write. In any other state nothing is stored.
- R5: Moving the address or changing the data while the chip is enabled for writing stores the data at each intermediate address.
- R6: If latch 1 bits 5..4 are not 0, no bank is selected. Writes then store nothing, and data-port reads in input mode return 0xFF.
- R7: A data-port read in input mode returns the SRAM byte at the current address when latch 1 bit 6 = 1, bit 7 = 1 and the bank exists. In every other input-mode case it returns 0xFF. In output mode the read returns the data latch.
- R8: The `contention` output is 1 exactly when latch 1 bit 6 = 1, bit 7 = 1 and the data port is an output. While it is 1, memory does not change.
- R9: After reset, latches 0, 1 and 2 are 0, the mode byte is 0x89, `rdata` is 0 and `contention` is 0.
- R10: `rdata` loads on the clock edge at which `rd_en` is sampled high. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| contention | output | 1 | Data port and SRAM outputs both driving |

## Verification
The assertions assume the host asserts `wr_en` and `rd_en` for one cycle per access and never drives `sel` to an unknown value while a strobe is high. The bench's bus tasks drive one strobe at a time on the falling edge and then leave the bus idle for one full cycle. Any pending store therefore lands before the next access. The bench reads back only SRAM cells it has written first, so no assertion or check ever depends on the power-up contents of the banks.

// File: rtl/cart_pkg.sv
package cart_pkg;
   typedef enum logic [1:0] {
      REG_ADDR_LO = 2'd0,
      REG_CTRL    = 2'd1,
      REG_DATA    = 2'd2,
      REG_MODE    = 2'd3
   } cart_reg_e;

   localparam int DW          = 8;
   localparam int BANK_AW     = 11;
   localparam int ADDR_W      = 12;
   localparam int BANK_IDX_W  = 3;
   localparam int CE_BIT      = 6;
   localparam int OE_BIT      = 7;
   localparam int DIR_IN_BIT  = 0;
   localparam logic [DW-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cart_ports.sv
module cart_ports
   import cart_pkg::*;
#(
   parameter logic [7:0] RESET_MODE = 8'h89
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] lat_a,
   output logic [DW-1:0] lat_b,
   output logic [DW-1:0] lat_c,
   output logic [DW-1:0] mode,
   output logic          upd
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
         mode  <= RESET_MODE;
         upd   <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (wr_en) begin
            unique case (cart_reg_e'(sel))
               REG_ADDR_LO: begin lat_a <= wdata; upd <= 1'b1; end
               REG_CTRL:    begin lat_b <= wdata; upd <= 1'b1; end
               REG_DATA:    begin lat_c <= wdata; upd <= 1'b1; end
               REG_MODE: begin
                  mode  <= wdata;
                  lat_a <= '0;
                  lat_b <= '0;
                  lat_c <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd3) |=> (lat_a == 0 && lat_b == 0 && lat_c == 0 && !upd));

   // R1
   addr_lo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == 2'd0) |=> (lat_a == $past(wdata) && upd));
endmodule

// File: rtl/cart_bank.sv
module cart_bank #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] rd
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wd;
   end

   assign rd = cells[addr];
endmodule

// File: rtl/ppi_sram_cart.sv
module ppi_sram_cart
   import cart_pkg::*;
#(
   parameter int         NUM_BANKS  = 2,
   parameter logic [7:0] RESET_MODE = 8'h89
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       contention
);
   localparam int IDX_HI = BANK_AW - 8 + BANK_IDX_W - 1;

   if (NUM_BANKS < 1 || NUM_BANKS > (1 << BANK_IDX_W)) begin : g_bad_banks
      $error("NUM_BANKS must lie between 1 and 8");
   end

   logic [DW-1:0] lat_a, lat_b, lat_c, mode;
   logic          upd;

   cart_ports #(.RESET_MODE(RESET_MODE)) u_ports (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .wr_en (wr_en),
      .wdata (wdata),
      .lat_a (lat_a),
      .lat_b (lat_b),
      .lat_c (lat_c),
      .mode  (mode),
      .upd   (upd)
   );

   logic [BANK_AW-1:0]    bank_addr;
   logic [BANK_IDX_W-1:0] bank_idx;
   logic                  chip_en, out_en, dir_in, store;

   assign bank_addr = {lat_b[BANK_AW-9:0], lat_a};
   assign bank_idx  = lat_b[IDX_HI:BANK_AW-8];
   assign chip_en   = lat_b[CE_BIT];
   assign out_en    = lat_b[OE_BIT];
   assign dir_in    = mode[DIR_IN_BIT];
   assign store     = upd && chip_en && !out_en && !dir_in;

   logic [NUM_BANKS-1:0] bank_we;
   logic [NUM_BANKS-1:0] bank_hit;
   logic [DW-1:0]        bank_rd [NUM_BANKS];

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      assign bank_hit[i] = (bank_idx == BANK_IDX_W'(i));
      assign bank_we[i]  = store && bank_hit[i];
      cart_bank #(.AW(BANK_AW), .DW(DW)) u_bank (
         .clk  (clk),
         .we   (bank_we[i]),
         .addr (bank_addr),
         .wd   (lat_c),
         .rd   (bank_rd[i])
      );
   end

   logic [DW-1:0] sram_byte;
   always_comb begin
      sram_byte = IDLE_BYTE;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (bank_hit[k] && chip_en && out_en) sram_byte = bank_rd[k];
      end
   end

   logic [DW-1:0] rd_mux;
   always_comb begin
      unique case (cart_reg_e'(sel))
         REG_ADDR_LO: rd_mux = lat_a;
         REG_CTRL:    rd_mux = lat_b;
         REG_DATA:    rd_mux = dir_in ? sram_byte : lat_c;
         REG_MODE:    rd_mux = mode;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   assign contention = chip_en && out_en && !dir_in;

   // R8
   no_store_in_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      contention |-> !(|bank_we));

   // R6
   single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

   // R4
   store_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|bank_we) |-> ($past(wr_en) && $past(sel) != 2'd3));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_ppi_sram_cart.sv
module test_ppi_sram_cart;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       contention;

   int n_checks = 0;
   int n_fail   = 0;

   ppi_sram_cart i_ppi_sram_cart (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (sel),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .wdata      (wdata),
      .rdata      (rdata),
      .contention (contention)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      sel = s; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      sel = s; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic mem_write(input logic [11:0] a, input logic [7:0] d);
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd2, d);
      bus_wr(2'd0, a[7:0]);
      bus_wr(2'd1, {4'b0100, a[11:8]});
      bus_wr(2'd1, {4'b0000, a[11:8]});
   endtask

   task automatic mem_read(input logic [11:0] a, output logic [7:0] d);
      bus_wr(2'd3, 8'h89);
      bus_wr(2'd0, a[7:0]);
      bus_wr(2'd1, {4'b1100, a[11:8]});
      bus_rd(2'd2, d);
      bus_wr(2'd1, 8'h80);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R9 contention", {7'b0, contention}, 8'h00);
      check("R9 rdata", rdata, 8'h00);
      bus_rd(2'd3, v); check("R9 mode", v, 8'h89);
      bus_rd(2'd0, v); check("R9 latch0", v, 8'h00);
      bus_rd(2'd1, v); check("R9 latch1", v, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] v;
      bus_wr(2'd0, 8'hA5);
      bus_wr(2'd1, 8'h23);
      bus_rd(2'd0, v); check("R1 latch0", v, 8'hA5);
      bus_rd(2'd1, v); check("R1 latch1", v, 8'h23);
      @(negedge clk);
      check("R10 hold", rdata, 8'h23);
   endtask

   task automatic t_ctrl_clear();
      logic [7:0] v;
      bus_wr(2'd3, 8'h80);
      bus_rd(2'd0, v); check("R3 latch0 cleared", v, 8'h00);
      bus_rd(2'd1, v); check("R3 latch1 cleared", v, 8'h00);
      bus_rd(2'd2, v); check("R3 data cleared", v, 8'h00);
      bus_rd(2'd3, v); check("R3 mode", v, 8'h80);
   endtask

   task automatic t_banks();
      logic [7:0] v;
      mem_write(12'h010, 8'h22);
      mem_write(12'h810, 8'h77);
      mem_read(12'h010, v); check("R4 bank0 store", v, 8'h22);
      mem_read(12'h810, v); check("R2 bank1 separate", v, 8'h77);
   endtask

   task automatic t_ripple();
      logic [7:0] v;
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd2, 8'h3C);
      bus_wr(2'd0, 8'h10);
      bus_wr(2'd1, 8'h41);
      bus_wr(2'd0, 8'h11);
      bus_wr(2'd0, 8'h12);
      bus_wr(2'd2, 8'h5A);
      bus_wr(2'd1, 8'h01);
      mem_read(12'h110, v); check("R5 first", v, 8'h3C);
      mem_read(12'h111, v); check("R5 intermediate", v, 8'h3C);
      mem_read(12'h112, v); check("R5 data change", v, 8'h5A);
   endtask

   task automatic t_nobank();
      logic [7:0] v;
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd2, 8'h99);
      bus_wr(2'd0, 8'h10);
      bus_wr(2'd1, 8'h50);
      bus_wr(2'd1, 8'h58);
      bus_wr(2'd1, 8'h00);
      mem_read(12'h010, v); check("R6 bank0 untouched", v, 8'h22);
      mem_read(12'h810, v); check("R6 bank1 untouched", v, 8'h77);
      bus_wr(2'd3, 8'h89);
      bus_wr(2'd0, 8'h10);
      bus_wr(2'd1, 8'hD0);
      bus_rd(2'd2, v); check("R6 read no bank", v, 8'hFF);
   endtask

   task automatic t_read_disabled();
      logic [7:0] v;
      bus_wr(2'd3, 8'h89);
      bus_wr(2'd0, 8'h10);
      bus_wr(2'd1, 8'h80);
      bus_rd(2'd2, v); check("R7 disabled reads FF", v, 8'hFF);
      bus_wr(2'd1, 8'h40);
      bus_rd(2'd2, v); check("R7 write-mode reads FF", v, 8'hFF);
      bus_wr(2'd0, 8'h11);
      bus_wr(2'd1, 8'h00);
      mem_read(12'h010, v); check("R4 no store in input mode", v, 8'h22);
   endtask

   task automatic t_contention();
      logic [7:0] v;
      bus_wr(2'd3, 8'h80);
      bus_wr(2'd0, 8'h10);
      check("R8 no flag yet", {7'b0, contention}, 8'h00);
      bus_wr(2'd1, 8'hC0);
      check("R8 flag", {7'b0, contention}, 8'h01);
      bus_wr(2'd2, 8'hEE);
      bus_rd(2'd2, v); check("R7 output mode returns latch", v, 8'hEE);
      bus_wr(2'd3, 8'h89);
      check("R3 flag cleared", {7'b0, contention}, 8'h00);
      mem_read(12'h010, v); check("R8 memory unchanged", v, 8'h22);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_ctrl_clear();
      t_banks();
      t_ripple();
      t_nobank();
      t_read_disabled();
      t_contention();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule